// File: doc/BRIEF.md
# Segment Decode and Translation Front-End

This block is the first stage of a 32-bit translator that walks a hashed page table. It receives an effective address together with the access type (instruction fetch, data load or data store), the privilege level, and separate translation-enable bits for instructions and for data. It holds sixteen segment registers. The top four address bits choose one of them.

From the chosen segment the block works out the protection key, the no-execute and direct-store flags, the compare tag and the two hash values that the table walker needs. It also makes the early decisions that need no walk:
- real-mode bypass;
- the forced-memory direct-store path;
- the no-execute fetch fault;
- the permission rules for ordinary direct-store segments.

Each accepted request produces a registered response exactly one cycle later. A small two-state controller drives the response strobe. State `ST_IDLE` means no response is pending. State `ST_RESP` means a response is on the outputs. The transition `IDLE->RESP` fires when a request arrives. `RESP->RESP` fires when requests come back to back. `RESP->IDLE` fires when no new request arrives, and `IDLE->IDLE` fires while the block is quiet.

Top module: `seg_xlate_front`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise; after reset it is low.
- R2: An access runs in real mode when `req_fetch`=1 with `xlat_i_en`=0, or `req_fetch`=0 with `xlat_d_en`=0. Real mode has priority over every other outcome. It gives `rsp_kind`=0, `rsp_paddr`=`req_ea` and `rsp_perm`=3'b111, where bit 2 is read, bit 1 is write and bit 0 is execute.
- R3: All segment registers reset to zero. A write with `sr_we` loads `sr_wdata` into register `sr_idx` at the clock edge. A request chooses register `req_ea[31:27+1]` (bits 31..28) using the value held before any write in that same cycle.
- R4: `rsp_key` is 1 when segment bit 29 is set for a user access (`req_user`=1), or when segment bit 30 is set for a supervisor access. Otherwise it is 0. `rsp_ds` reports segment bit 31 and `rsp_nx` reports segment bit 28.
- R5: `rsp_tag` equals (segment bits 23:0 shifted left by 7) OR (`req_ea[27:12]` shifted right by 10).
- R6: `rsp_hash_p` is segment bits 18:0 XOR the zero-extended `req_ea[27:12]`, and `rsp_hash_s` is its bitwise complement.
- R7: A translated fetch from a segment that is not direct-store and has no-execute set gives `rsp_kind`=2, with `rsp_paddr`=0 and `rsp_perm`=0.
- R8: A translated access to a direct-store segment whose bits 28:20 equal 0x07F gives `rsp_kind`=3 and `rsp_perm`=3'b111. Its `rsp_paddr` is segment bits 3:0 followed by `req_ea[27:0]`.
- R9: In any other direct-store segment:
  - A fetch gives `rsp_kind`=5.
  - A store with key 1, or a load with key 0, gives `rsp_kind`=5.
  - Both `rsp_kind`=5 cases give `rsp_paddr`=0 and `rsp_perm`=0.
  - Any other load or store gives `rsp_kind`=4 with `rsp_paddr`=`req_ea`, and `rsp_perm` is 3'b100 for a load or 3'b010 for a store.
- R10: Every other translated access (non-direct-store, and not a no-execute fetch) gives `rsp_kind`=1, meaning walk the table, with `rsp_paddr`=0 and `rsp_perm`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_we | input | 1 | Segment register write enable |
| sr_idx | input | 4 | Segment register write index |
| sr_wdata | input | 32 | Segment register write data |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_store | input | 1 | 1 = data store, 0 = data load (ignored on fetch) |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| xlat_i_en | input | 1 | Instruction translation enable |
| xlat_d_en | input | 1 | Data translation enable |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 3 | Outcome code |
| rsp_paddr | output | 32 | Physical address for resolved outcomes |
| rsp_perm | output | 3 | Granted read/write/execute |
| rsp_key | output | 1 | Protection key |
| rsp_nx | output | 1 | Segment no-execute flag |
| rsp_ds | output | 1 | Segment direct-store flag |
| rsp_tag | output | 32 | Page compare tag |
| rsp_hash_p | output | 19 | Primary hash |
| rsp_hash_s | output | 19 | Secondary hash |

## Verification
The assertions watch the following on every cycle:
- the response strobe timing;
- the complement relation between the two hashes;
- the real-mode address and permissions;
- the full grant on the forced path;
- the empty permissions of every fault and walk outcome;
- the tag's low bits against the address one cycle earlier.

Segment selection, the key truth table under each privilege, and the read-before-write behaviour of a segment write in the same cycle as a request can only be shown by the bench's sweeps. The same holds for the priority between real mode, direct-store and no-execute. The sweeps cover every segment under every access type, privilege level and enable pair.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int EA_W     = 32;
    localparam int SR_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int PIDX_W   = 16;
    localparam int VSID_W   = 24;
    localparam int HASH_W   = 19;
    localparam int API_SH   = 10;
    localparam int TAG_SH   = 7;

    // bit positions decoded from a segment register
    localparam int SRB_DS   = 31;
    localparam int SRB_KSUP = 30;
    localparam int SRB_KUSR = 29;
    localparam int SRB_NX   = 28;
    localparam int BUID_HI  = 28;
    localparam int BUID_LO  = 20;
    localparam logic [8:0] BUID_FORCED = 9'h07F;

    typedef enum logic [2:0] {
        KIND_REAL   = 3'd0,
        KIND_WALK   = 3'd1,
        KIND_NXF    = 3'd2,
        KIND_FORCED = 3'd3,
        KIND_DSOK   = 3'd4,
        KIND_DSF    = 3'd5
    } kind_e;

    localparam logic [2:0] PERM_ALL = 3'b111;
    localparam logic [2:0] PERM_RD  = 3'b100;
    localparam logic [2:0] PERM_WR  = 3'b010;
    localparam logic [2:0] PERM_NONE = 3'b000;

    typedef struct packed {
        kind_e               kind;
        logic [EA_W-1:0]     paddr;
        logic [2:0]          perm;
        logic                key;
        logic                nx;
        logic                ds;
        logic [EA_W-1:0]     tag;
        logic [HASH_W-1:0]   hash_p;
        logic [HASH_W-1:0]   hash_s;
    } xlate_rsp_t;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int NUM_SEG = 16,
    parameter int WIDTH   = 32,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] seg_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                seg_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = seg_q[rd_idx];

endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import seg_xlate_pkg::*;
(
    input  logic [SR_W-1:0] seg,
    input  logic [EA_W-1:0] ea,
    input  logic            fetch,
    input  logic            store,
    input  logic            user,
    input  logic            i_en,
    input  logic            d_en,
    output xlate_rsp_t      res
);

    logic [VSID_W-1:0] vsid;
    logic [PIDX_W-1:0] pidx;
    logic [8:0]        buid;
    logic              key;
    logic              real_mode;
    logic              ds_deny;

    always_comb begin
        vsid = seg[VSID_W-1:0];
        pidx = ea[PG_SHIFT+PIDX_W-1:PG_SHIFT];
        buid = seg[BUID_HI:BUID_LO];
        key  = (seg[SRB_KUSR] & user) | (seg[SRB_KSUP] & ~user);
        real_mode = fetch ? ~i_en : ~d_en;
        ds_deny = fetch | (store & key) | (~store & ~key);

        res        = '0;
        res.key    = key;
        res.nx     = seg[SRB_NX];
        res.ds     = seg[SRB_DS];
        res.tag    = (EA_W'(vsid) << TAG_SH) | EA_W'(pidx >> API_SH);
        res.hash_p = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
        res.hash_s = ~res.hash_p;

        if (real_mode) begin
            res.kind  = KIND_REAL;
            res.paddr = ea;
            res.perm  = PERM_ALL;
        end else if (seg[SRB_DS]) begin
            if (buid == BUID_FORCED) begin
                res.kind  = KIND_FORCED;
                res.paddr = {seg[3:0], ea[EA_W-5:0]};
                res.perm  = PERM_ALL;
            end else if (ds_deny) begin
                res.kind  = KIND_DSF;
                res.paddr = '0;
                res.perm  = PERM_NONE;
            end else begin
                res.kind  = KIND_DSOK;
                res.paddr = ea;
                res.perm  = store ? PERM_WR : PERM_RD;
            end
        end else if (fetch && seg[SRB_NX]) begin
            res.kind  = KIND_NXF;
            res.paddr = '0;
            res.perm  = PERM_NONE;
        end else begin
            res.kind  = KIND_WALK;
            res.paddr = '0;
            res.perm  = PERM_NONE;
        end
    end

endmodule

// File: rtl/seg_rsp_fsm.sv
module seg_rsp_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic load_rsp,
    output logic rsp_valid
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;

    st_e state_q;
    st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        load_rsp  = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_rsp = req_valid;
                state_d  = req_valid ? ST_RESP : ST_IDLE;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                load_rsp  = req_valid;
                state_d   = req_valid ? ST_RESP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 16,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_we,
    input  logic [IDX_W-1:0]  sr_idx,
    input  logic [SR_W-1:0]   sr_wdata,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_fetch,
    input  logic              req_store,
    input  logic              req_user,
    input  logic              xlat_i_en,
    input  logic              xlat_d_en,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [EA_W-1:0]   rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic              rsp_key,
    output logic              rsp_nx,
    output logic              rsp_ds,
    output logic [EA_W-1:0]   rsp_tag,
    output logic [HASH_W-1:0] rsp_hash_p,
    output logic [HASH_W-1:0] rsp_hash_s
);

    logic [SR_W-1:0] seg_sel;
    xlate_rsp_t      dec;
    xlate_rsp_t      rsp_q;
    logic            load_rsp;

    seg_regfile #(.NUM_SEG(NUM_SEG), .WIDTH(SR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_we),
        .wr_idx  (sr_idx),
        .wr_data (sr_wdata),
        .rd_idx  (req_ea[EA_W-1 -: IDX_W]),
        .rd_data (seg_sel)
    );

    seg_decode u_dec (
        .seg   (seg_sel),
        .ea    (req_ea),
        .fetch (req_fetch),
        .store (req_store),
        .user  (req_user),
        .i_en  (xlat_i_en),
        .d_en  (xlat_d_en),
        .res   (dec)
    );

    seg_rsp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .load_rsp  (load_rsp),
        .rsp_valid (rsp_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else if (load_rsp) begin
            rsp_q <= dec;
        end
    end

    assign rsp_kind   = rsp_q.kind;
    assign rsp_paddr  = rsp_q.paddr;
    assign rsp_perm   = rsp_q.perm;
    assign rsp_key    = rsp_q.key;
    assign rsp_nx     = rsp_q.nx;
    assign rsp_ds     = rsp_q.ds;
    assign rsp_tag    = rsp_q.tag;
    assign rsp_hash_p = rsp_q.hash_p;
    assign rsp_hash_s = rsp_q.hash_s;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_ea,
    input logic        rsp_valid,
    input logic [2:0]  rsp_kind,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_perm,
    input logic        rsp_nx,
    input logic        rsp_ds,
    input logic [31:0] rsp_tag,
    input logic [18:0] rsp_hash_p,
    input logic [18:0] rsp_hash_s
);

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    real_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) && rsp_kind == 3'd0
        |-> rsp_paddr == $past(req_ea) && rsp_perm == 3'b111);

    // R5
    tag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> rsp_tag[5:0] == $past(req_ea[27:22]));

    // R6
    hash_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hash_p ^ rsp_hash_s) == 19'h7FFFF);

    // R7
    nx_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == 3'd2 |-> rsp_nx && !rsp_ds && rsp_perm == 3'b000);

    // R8
    forced_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == 3'd3
        |-> rsp_ds && rsp_perm == 3'b111 && rsp_paddr[27:0] == $past(req_ea[27:0]));

    // R9
    ds_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == 3'd5 |-> rsp_ds && rsp_perm == 3'b000);

    // R10
    walk_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == 3'd1 |-> !rsp_ds && rsp_perm == 3'b000 && rsp_paddr == 32'd0);

endmodule

bind seg_xlate_front seg_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ea     (req_ea),
    .rsp_valid  (rsp_valid),
    .rsp_kind   (rsp_kind),
    .rsp_paddr  (rsp_paddr),
    .rsp_perm   (rsp_perm),
    .rsp_nx     (rsp_nx),
    .rsp_ds     (rsp_ds),
    .rsp_tag    (rsp_tag),
    .rsp_hash_p (rsp_hash_p),
    .rsp_hash_s (rsp_hash_s)
);

// File: tb/seg_xlate_front_tb.sv
module seg_xlate_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_we = 1'b0;
    logic [3:0]  sr_idx = '0;
    logic [31:0] sr_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_fetch = 1'b0;
    logic        req_store = 1'b0;
    logic        req_user = 1'b0;
    logic        xlat_i_en = 1'b0;
    logic        xlat_d_en = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_kind;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic        rsp_key;
    logic        rsp_nx;
    logic        rsp_ds;
    logic [31:0] rsp_tag;
    logic [18:0] rsp_hash_p;
    logic [18:0] rsp_hash_s;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model_sr [16];

    always #5 clk = ~clk;

    seg_xlate_front u_dut (
        .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_idx(sr_idx), .sr_wdata(sr_wdata),
        .req_valid(req_valid), .req_ea(req_ea), .req_fetch(req_fetch),
        .req_store(req_store), .req_user(req_user), .xlat_i_en(xlat_i_en),
        .xlat_d_en(xlat_d_en), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_key(rsp_key),
        .rsp_nx(rsp_nx), .rsp_ds(rsp_ds), .rsp_tag(rsp_tag),
        .rsp_hash_p(rsp_hash_p), .rsp_hash_s(rsp_hash_s)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_sr(input int idx, input logic [31:0] val);
        @(negedge clk);
        sr_we = 1'b1; sr_idx = 4'(idx); sr_wdata = val;
        @(negedge clk);
        sr_we = 1'b0;
        model_sr[idx] = val;
    endtask

    // compute and compare a response against an independent model
    task automatic expect_rsp(input logic [31:0] sr, input logic [31:0] ea, input bit f,
                              input bit st, input bit u, input bit ie, input bit de);
        logic [2:0]  k;
        logic [31:0] pa;
        logic [2:0]  pm;
        logic        key;
        logic [15:0] pidx;
        logic [31:0] tag;
        logic [18:0] hp;
        key  = (sr[29] && u) || (sr[30] && !u);
        pidx = ea[27:12];
        tag  = (32'(sr[23:0]) << 7) | 32'(pidx >> 10);
        hp   = sr[18:0] ^ {3'b000, pidx};
        if ((f && !ie) || (!f && !de)) begin
            k = 3'd0; pa = ea; pm = 3'b111;
        end else if (sr[31]) begin
            if (sr[28:20] == 9'h07F) begin
                k = 3'd3; pa = {sr[3:0], ea[27:0]}; pm = 3'b111;
            end else if (f || (st && key) || (!st && !key)) begin
                k = 3'd5; pa = 0; pm = 0;
            end else begin
                k = 3'd4; pa = ea; pm = st ? 3'b010 : 3'b100;
            end
        end else if (f && sr[28]) begin
            k = 3'd2; pa = 0; pm = 0;
        end else begin
            k = 3'd1; pa = 0; pm = 0;
        end
        chk(rsp_valid === 1'b1, "R1 valid", 32'(rsp_valid), 1);
        case (k)
            3'd0: chk(rsp_kind === k && rsp_paddr === pa && rsp_perm === pm, "R2 real", rsp_paddr, pa);
            3'd1: chk(rsp_kind === k && rsp_paddr === pa && rsp_perm === pm, "R10 walk", 32'(rsp_kind), 32'(k));
            3'd2: chk(rsp_kind === k && rsp_perm === pm, "R7 nx fetch", 32'(rsp_kind), 32'(k));
            3'd3: chk(rsp_kind === k && rsp_paddr === pa && rsp_perm === pm, "R8 forced", rsp_paddr, pa);
            default: chk(rsp_kind === k && rsp_paddr === pa && rsp_perm === pm, "R9 direct-store",
                         {rsp_kind, rsp_perm, rsp_paddr[25:0]}, {k, pm, pa[25:0]});
        endcase
        chk(rsp_key === key && rsp_ds === sr[31] && rsp_nx === sr[28], "R4 key/flags",
            {29'd0, rsp_key, rsp_ds, rsp_nx}, {29'd0, key, sr[31], sr[28]});
        chk(rsp_tag === tag, "R5 tag", rsp_tag, tag);
        chk(rsp_hash_p === hp && rsp_hash_s === ~hp, "R6 hash", 32'(rsp_hash_p), 32'(hp));
    endtask

    task automatic do_req(input logic [31:0] ea, input bit f, input bit st, input bit u,
                          input bit ie, input bit de);
        logic [31:0] sr;
        sr = model_sr[ea[31:28]];
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_fetch = f; req_store = st;
        req_user = u; xlat_i_en = ie; xlat_d_en = de;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp(sr, ea, f, st, u, ie, de);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int k;
        for (int i = 0; i < 16; i++) model_sr[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rsp_valid === 1'b0, "R1 reset valid", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 idle valid", 32'(rsp_valid), 0);

        // R3 reset-zero segments: walk with tag and hash from page index only
        do_req(32'h7ABC_D123, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        do_req(32'hF001_2000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 drop after single", 32'(rsp_valid), 0);

        k = 0;
        for (int set = 0; set < 2; set++) begin
            for (int i = 0; i < 16; i++) begin
                logic [31:0] v;
                logic [3:0]  ib;
                ib = 4'(i);
                if (set == 0) begin
                    v = {ib, 4'h0, 24'(i * 24'h0A5B3 + 24'h31C7)};
                end else if (ib[0] == 1'b0) begin
                    v = {1'b1, ib[2], ib[1], 9'h07F, 16'(i * 16'h1111), ib ^ 4'h5};
                end else begin
                    v = {1'b1, ib[2], ib[1], 9'h07E, 16'(i * 16'h0F0F), ib};
                end
                write_sr(i, v);
            end
            for (int i = 0; i < 16; i++) begin
                for (int acc = 0; acc < 3; acc++) begin
                    for (int u = 0; u < 2; u++) begin
                        for (int en = 0; en < 4; en++) begin
                            logic [31:0] ea;
                            k++;
                            ea = {4'(i), 28'((k * 32'h9E37_79B1) >> 4)};
                            // R3 segment selected by top nibble
                            do_req(ea, acc == 2, acc == 1, u[0], en[0], en[1]);
                        end
                    end
                end
            end
        end

        // R3 write in the same cycle as a request: old value used, new one after
        write_sr(3, 32'h0000_0001);
        @(negedge clk);
        req_valid = 1'b1; req_ea = 32'h3000_5000; req_fetch = 1'b0; req_store = 1'b0;
        req_user = 1'b0; xlat_i_en = 1'b1; xlat_d_en = 1'b1;
        sr_we = 1'b1; sr_idx = 4'd3; sr_wdata = 32'h8000_0002;
        @(negedge clk);
        req_valid = 1'b0; sr_we = 1'b0;
        chk(rsp_kind === 3'd1 && rsp_hash_p === 19'h00004, "R3 read before write",
            32'(rsp_hash_p), 32'h4);
        model_sr[3] = 32'h8000_0002;
        do_req(32'h3000_5000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

        // R1 back-to-back requests keep valid high
        @(negedge clk);
        req_valid = 1'b1; req_ea = 32'h0000_1000; req_fetch = 1'b0; req_store = 1'b0;
        @(negedge clk);
        chk(rsp_valid === 1'b1, "R1 b2b first", 32'(rsp_valid), 1);
        req_ea = 32'h1000_2000;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1 && rsp_tag[5:0] === 6'd0, "R1 b2b second", 32'(rsp_valid), 1);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 b2b end", 32'(rsp_valid), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule